// File: doc/BRIEF.md
# Rotating interrupt priority resolver

This block decides which of eight interrupt request lines should be handed to the processor next. It takes a request vector, a mask vector, an in-service vector, a rotation offset and two mode flags. It reports whether an unmasked request outranks every interrupt currently being serviced, and which line that request is on. The rotation offset sets which line holds the top priority. Each line after it in circular order ranks one step lower. The block also reports the highest-priority in-service line, so that a non-specific end-of-interrupt command knows which bit to clear.

The priority search is a barrel rotate followed by a fixed lowest-index-first encoder. Three copies of it run side by side: one on the candidate requests, one on the effective in-service vector, and one on the raw in-service vector. The storage of the three vectors, the decoding of commands and the cascade wiring all sit outside this block. A parameter places an optional register stage on the outputs. With that stage fitted, every result appears one clock after its inputs, and the outputs clear on reset.

The results are continuous status signals that are re-evaluated every cycle, not a data stream. They therefore carry no handshake and there is no back-pressure to manage. The consumer samples them whenever it needs to.

Top module: `prio_resolver`

## Requirements
- R1: A line is a candidate only when its request bit is 1 and its mask bit is 0. A masked line is never reported as the winner.
- R2: Priority level p maps to line (p + rot_ofs) mod 8, and level 0 is the highest priority. The winner is the candidate with the lowest level, so the line equal to rot_ofs ranks first.
- R3: With no candidate, irq_valid is 0.
- R4: The current service level is found by the same search applied to the effective in-service vector. irq_valid is 1 only when the winner's level is strictly lower, in number, than that level. A request at the same level or at a numerically higher level is held back.
- R5: When nest_mode is 1 and the block is the primary controller (IS_PRIMARY=1), in-service bit CASCADE_LINE (default 2) is dropped before the service level is computed. A request on that line can then interrupt its own in-service state.
- R6: When smask_mode is 1, in-service bits whose mask bit is 1 are ignored in the service-level computation.
- R7: svc_valid is 1 when any raw in-service bit is set. svc_line is the highest-priority set line of the raw in-service vector under the same rotation. Both are unaffected by mask, nest_mode and smask_mode.
- R8: With REG_OUT=1 (the default), every output changes one clock edge after its inputs, and all outputs are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | LINES | Request vector |
| mask | input | LINES | Mask vector, 1 = masked |
| insvc | input | LINES | In-service vector |
| rot_ofs | input | IDX_W | Line that holds priority level 0 |
| nest_mode | input | 1 | Special fully nested mode: drop the cascade bit from in-service |
| smask_mode | input | 1 | Special mask mode: ignore masked in-service bits |
| irq_valid | output | 1 | An unmasked request outranks the current service level |
| irq_line | output | IDX_W | Winning line, meaningful when irq_valid is 1 |
| svc_valid | output | 1 | At least one in-service bit is set |
| svc_line | output | IDX_W | Highest-priority in-service line, meaningful when svc_valid is 1 |

## Verification
The checker assumes that inputs are stable across each sampling edge and that rot_ofs always names a real line. It does not assume that the in-service vector is one-hot or that it relates to the requests in any way, and the stimulus exploits this. All inputs change at the falling clock edge, so every rising edge sees settled values. Directed cases cover each mode and corner with hand-worked results. A pseudo-random sweep then drives arbitrary vectors, offsets and mode flags, each compared against a reference written from the requirements.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int unsigned DEF_LINES    = 8;
  localparam int unsigned DEF_CASCADE  = 2;

  typedef enum logic [1:0] {
    SRC_REQ  = 2'd0,
    SRC_CUR  = 2'd1,
    SRC_SVC  = 2'd2
  } search_src_e;

  localparam int unsigned NUM_SEARCH = 3;
endpackage

// File: rtl/prio_rotator.sv
module prio_rotator #(
  parameter int unsigned LINES = 8,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] vec,
  input  logic [IDX_W-1:0] ofs,
  output logic [LINES-1:0] rot
);
  localparam logic [IDX_W:0] N_EXT = (IDX_W+1)'(LINES);

  always_comb begin
    for (int p = 0; p < LINES; p++) begin
      logic [IDX_W:0] s;
      s = (IDX_W+1)'(p) + {1'b0, ofs};
      if (s >= N_EXT) s = s - N_EXT;
      rot[p] = vec[s[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/prio_encoder.sv
module prio_encoder #(
  parameter int unsigned LINES = 8,
  localparam int unsigned LVL_W = $clog2(LINES+1)
) (
  input  logic [LINES-1:0] vec,
  output logic [LVL_W-1:0] lvl
);
  localparam logic [LVL_W-1:0] NONE_LVL = LVL_W'(LINES);

  always_comb begin
    lvl = NONE_LVL;
    for (int i = LINES-1; i >= 0; i--) begin
      if (vec[i]) lvl = LVL_W'(i);
    end
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_pkg::*;
#(
  parameter int unsigned LINES        = DEF_LINES,
  parameter int unsigned CASCADE_LINE = DEF_CASCADE,
  parameter bit          IS_PRIMARY   = 1'b1,
  parameter bit          REG_OUT      = 1'b1,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned LVL_W = $clog2(LINES+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] insvc,
  input  logic [IDX_W-1:0] rot_ofs,
  input  logic             nest_mode,
  input  logic             smask_mode,
  output logic             irq_valid,
  output logic [IDX_W-1:0] irq_line,
  output logic             svc_valid,
  output logic [IDX_W-1:0] svc_line
);
  localparam logic [IDX_W:0]   N_EXT    = (IDX_W+1)'(LINES);
  localparam logic [LVL_W-1:0] NONE_LVL = LVL_W'(LINES);

  logic [LINES-1:0] cand;
  logic [LINES-1:0] isv_eff;
  logic [LINES-1:0] src [NUM_SEARCH];
  logic [LINES-1:0] rot [NUM_SEARCH];
  logic [LVL_W-1:0] lvl [NUM_SEARCH];

  assign cand = req & ~mask;

  always_comb begin
    isv_eff = insvc;
    if (IS_PRIMARY && nest_mode) isv_eff[CASCADE_LINE] = 1'b0;
    if (smask_mode) isv_eff = isv_eff & ~mask;
  end

  assign src[SRC_REQ] = cand;
  assign src[SRC_CUR] = isv_eff;
  assign src[SRC_SVC] = insvc;

  for (genvar g = 0; g < NUM_SEARCH; g++) begin : g_search
    prio_rotator #(.LINES(LINES)) u_rot (
      .vec (src[g]),
      .ofs (rot_ofs),
      .rot (rot[g])
    );
    prio_encoder #(.LINES(LINES)) u_enc (
      .vec (rot[g]),
      .lvl (lvl[g])
    );
  end

  function automatic logic [IDX_W-1:0] lvl_to_line(input logic [LVL_W-1:0] l,
                                                   input logic [IDX_W-1:0] o);
    logic [IDX_W:0] s;
    s = {1'b0, l[IDX_W-1:0]} + {1'b0, o};
    if (s >= N_EXT) s = s - N_EXT;
    return s[IDX_W-1:0];
  endfunction

  logic             win_c;
  logic [IDX_W-1:0] win_line_c;
  logic             svc_c;
  logic [IDX_W-1:0] svc_line_c;

  assign win_c      = lvl[SRC_REQ] < lvl[SRC_CUR];
  assign win_line_c = lvl_to_line(lvl[SRC_REQ], rot_ofs);
  assign svc_c      = lvl[SRC_SVC] != NONE_LVL;
  assign svc_line_c = lvl_to_line(lvl[SRC_SVC], rot_ofs);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_valid <= 1'b0;
        irq_line  <= '0;
        svc_valid <= 1'b0;
        svc_line  <= '0;
      end else begin
        irq_valid <= win_c;
        irq_line  <= win_line_c;
        svc_valid <= svc_c;
        svc_line  <= svc_line_c;
      end
    end
  end else begin : g_comb
    assign irq_valid = win_c;
    assign irq_line  = win_line_c;
    assign svc_valid = svc_c;
    assign svc_line  = svc_line_c;
  end
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int unsigned LINES   = 8,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] req,
  input logic [LINES-1:0] mask,
  input logic [LINES-1:0] insvc,
  input logic [IDX_W-1:0] rot_ofs,
  input logic             nest_mode,
  input logic             smask_mode,
  input logic             irq_valid,
  input logic [IDX_W-1:0] irq_line,
  input logic             svc_valid,
  input logic [IDX_W-1:0] svc_line
);
  logic [LINES-1:0] d_req, d_mask, d_insvc;
  logic [IDX_W-1:0] d_ofs;
  logic             d_nest, d_smask;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_req <= '0; d_mask <= '0; d_insvc <= '0; d_ofs <= '0;
        d_nest <= 1'b0; d_smask <= 1'b0;
      end else begin
        d_req <= req; d_mask <= mask; d_insvc <= insvc; d_ofs <= rot_ofs;
        d_nest <= nest_mode; d_smask <= smask_mode;
      end
    end
  end else begin : g_now
    assign d_req = req;   assign d_mask = mask; assign d_insvc = insvc;
    assign d_ofs = rot_ofs; assign d_nest = nest_mode; assign d_smask = smask_mode;
  end

  AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (d_req[irq_line] && !d_mask[irq_line])); // R1
  AST_OFFSET_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req[d_ofs] && !d_mask[d_ofs] && d_insvc == '0) |-> (irq_valid && irq_line == d_ofs)); // R2
  AST_NO_CAND_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((d_req & ~d_mask) == '0) |-> !irq_valid); // R3
  AST_IDLE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (d_insvc == '0 && (d_req & ~d_mask) != '0) |-> irq_valid); // R4
  AST_INSVC_NOT_REENTERED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !d_nest && !d_smask) |-> !d_insvc[irq_line]); // R4
  AST_SVC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid == (d_insvc != '0)); // R7
  AST_SVC_LINE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> d_insvc[svc_line]); // R7
endmodule

bind prio_resolver prio_resolver_chk #(.LINES(LINES), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .mask(mask), .insvc(insvc),
  .rot_ofs(rot_ofs), .nest_mode(nest_mode), .smask_mode(smask_mode),
  .irq_valid(irq_valid), .irq_line(irq_line),
  .svc_valid(svc_valid), .svc_line(svc_line)
);

// File: tb/prio_resolver_bench.sv
module prio_resolver_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mask = '0, insvc = '0;
  logic [2:0] rot_ofs = '0;
  logic       nest_mode = 1'b0, smask_mode = 1'b0;
  logic       irq_valid, svc_valid;
  logic [2:0] irq_line, svc_line;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  prio_resolver u_prio_resolver (
    .clk(clk), .rst_n(rst_n), .req(req), .mask(mask), .insvc(insvc),
    .rot_ofs(rot_ofs), .nest_mode(nest_mode), .smask_mode(smask_mode),
    .irq_valid(irq_valid), .irq_line(irq_line),
    .svc_valid(svc_valid), .svc_line(svc_line)
  );

  function automatic logic [7:0] pack(input logic v, input logic [2:0] l,
                                      input logic sv, input logic [2:0] sl);
    return {v, v ? l : 3'd0, sv, sv ? sl : 3'd0};
  endfunction

  task automatic expect_out(input string tag, input logic ev, input logic [2:0] el,
                            input logic es, input logic [2:0] esl);
    logic [7:0] got, exp;
    got = pack(irq_valid, irq_line, svc_valid, svc_line);
    exp = pack(ev, el, es, esl);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got v=%0b line=%0d sv=%0b sline=%0d, expected v=%0b line=%0d sv=%0b sline=%0d",
               tag, got[7], got[6:4], got[3], got[2:0], exp[7], exp[6:4], exp[3], exp[2:0]);
    end
  endtask

  task automatic apply(input logic [7:0] rq, input logic [7:0] mk, input logic [7:0] is,
                       input logic [2:0] of, input logic nm, input logic sm);
    @(negedge clk);
    req = rq; mask = mk; insvc = is; rot_ofs = of; nest_mode = nm; smask_mode = sm;
    @(negedge clk);
  endtask

  function automatic void model(input logic [7:0] rq, mk, is, input logic [2:0] of,
                                input logic nm, sm, output logic ev, output logic [2:0] el,
                                output logic es, output logic [2:0] esl);
    logic [7:0] cand, eff;
    int rl, cl, sl;
    cand = rq & ~mk;
    eff = is;
    if (nm) eff[2] = 1'b0;
    if (sm) eff = eff & ~mk;
    rl = 8; cl = 8; sl = 8;
    for (int p = 7; p >= 0; p--) begin
      int ln;
      ln = (p + int'(of)) % 8;
      if (cand[ln]) rl = p;
      if (eff[ln])  cl = p;
      if (is[ln])   sl = p;
    end
    ev = rl < cl;
    el = 3'((rl + int'(of)) % 8);
    es = sl < 8;
    esl = 3'((sl + int'(of)) % 8);
  endfunction

  task automatic t_reset();
    #1;
    expect_out("R8 reset outputs", 1'b0, 3'd0, 1'b0, 3'd0);
  endtask

  task automatic t_basic();
    apply(8'h10, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0);
    expect_out("R2 single request line 4", 1'b1, 3'd4, 1'b0, 3'd0);
    apply(8'h90, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0);
    expect_out("R2 lowest line wins offset 0", 1'b1, 3'd4, 1'b0, 3'd0);
  endtask

  task automatic t_mask();
    apply(8'h10, 8'h10, 8'h00, 3'd0, 1'b0, 1'b0);
    expect_out("R1 masked request ignored", 1'b0, 3'd0, 1'b0, 3'd0);
    apply(8'h30, 8'h10, 8'h00, 3'd0, 1'b0, 1'b0);
    expect_out("R1 masked line skipped", 1'b1, 3'd5, 1'b0, 3'd0);
    apply(8'h00, 8'h00, 8'h00, 3'd3, 1'b0, 1'b0);
    expect_out("R3 no request", 1'b0, 3'd0, 1'b0, 3'd0);
  endtask

  task automatic t_rotate();
    apply(8'h41, 8'h00, 8'h00, 3'd5, 1'b0, 1'b0);
    expect_out("R2 offset 5 picks line 6", 1'b1, 3'd6, 1'b0, 3'd0);
    apply(8'h81, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0);
    expect_out("R2 offset 7 picks line 7", 1'b1, 3'd7, 1'b0, 3'd0);
    apply(8'h81, 8'h00, 8'h00, 3'd1, 1'b0, 1'b0);
    expect_out("R2 offset 1 wraps to line 7", 1'b1, 3'd7, 1'b0, 3'd0);
  endtask

  task automatic t_service();
    apply(8'h02, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0);
    expect_out("R4 higher request preempts", 1'b1, 3'd1, 1'b1, 3'd3);
    apply(8'h08, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0);
    expect_out("R4 equal level held", 1'b0, 3'd0, 1'b1, 3'd3);
    apply(8'h20, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0);
    expect_out("R4 lower priority held", 1'b0, 3'd0, 1'b1, 3'd3);
  endtask

  task automatic t_nested();
    apply(8'h04, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0);
    expect_out("R5 cascade blocked without nest mode", 1'b0, 3'd0, 1'b1, 3'd2);
    apply(8'h04, 8'h00, 8'h04, 3'd0, 1'b1, 1'b0);
    expect_out("R5 cascade reenters in nest mode", 1'b1, 3'd2, 1'b1, 3'd2);
  endtask

  task automatic t_smask();
    apply(8'h20, 8'h01, 8'h01, 3'd0, 1'b0, 1'b0);
    expect_out("R6 masked in-service still blocks", 1'b0, 3'd0, 1'b1, 3'd0);
    apply(8'h20, 8'h01, 8'h01, 3'd0, 1'b0, 1'b1);
    expect_out("R6 special mask lets line 5 through", 1'b1, 3'd5, 1'b1, 3'd0);
  endtask

  task automatic t_svc();
    apply(8'h00, 8'hFF, 8'h81, 3'd4, 1'b1, 1'b1);
    expect_out("R7 svc line under rotation ignores modes", 1'b0, 3'd0, 1'b1, 3'd7);
  endtask

  task automatic t_latency();
    apply(8'h01, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0);
    @(negedge clk);
    req = 8'h40;
    #1;
    expect_out("R8 output holds before edge", 1'b1, 3'd0, 1'b0, 3'd0);
    @(negedge clk);
    expect_out("R8 output follows after edge", 1'b1, 3'd6, 1'b0, 3'd0);
  endtask

  task automatic t_sweep();
    logic [31:0] lf;
    lf = 32'h1234_5678;
    for (int k = 0; k < 400; k++) begin
      logic ev, es;
      logic [2:0] el, esl;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      apply(lf[7:0], lf[15:8] & lf[23:16], lf[23:16] & lf[31:24],
            lf[26:24], lf[27], lf[29]);
      model(req, mask, insvc, rot_ofs, nest_mode, smask_mode, ev, el, es, esl);
      expect_out("R1 R2 R4 R5 R6 R7 sweep", ev, el, es, esl);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    req = 8'hFF; insvc = 8'hFF;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_mask();
    t_rotate();
    t_service();
    t_nested();
    t_smask();
    t_svc();
    t_latency();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule